// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller for five ports of eight pins each. Software reaches four 16-bit registers per port over a simple write-strobe bus: a mode register, a data register, an interrupt setup register and a sticky interrupt flag register. Each pin can be a plain input, a driven output, or an input whose edges raise a flag. Pads are modelled as separate output-enable and output-value vectors, so the tri-state buffer is left to the pad ring.

Input pins pass through a two-stage synchronizer. In edge mode, a rising or a falling transition, chosen per pin, sets the pin's flag bit. Software clears the flag by writing a one to it. All flag bits that are not masked feed one registered, active-high interrupt line, which is shared by every port.

A pin is identified by a 6-bit index. The port number sits in bits [5:3] and the pin number in bits [2:0]. Pin `8*port + pin` maps to bit `8*port + pin` of the pin and pad vectors.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every mode field is 00 (input), every mask bit is 1, every flag bit is 0, `irq` is 0 and `pad_oe` is all zero. The setup register therefore reads 0x00FF.
- R2: A pin drives its pad (`pad_oe` bit = 1) only when its mode field is 01. `pad_out` carries the pin's data register bit, and it changes only after a data register write.
- R3: A data register read returns, in bits [7:0], the written data bit for pins in mode 01 and the synchronized input for every other pin. An input change is visible two clock edges after it is applied. Bits [15:8] read 0.
- R4: The byte address is {kind[1:0], port[2:0], 0}, with kind 0 = mode, 1 = data, 2 = interrupt setup, 3 = flags. Port n of a kind sits at that kind's base plus 2·n. A write to one port leaves every other port unchanged. Odd addresses and port codes of 5 and above read 0 and ignore writes.
- R5: The mode register holds pin p's mode in bits [2p+1:2p]. Only mode 11 enables edge detection. Setup bit 8+p = 1 selects the rising edge and 0 selects the falling edge. The flag bit is set on the third clock edge after the pin input changes.
- R6: A flag bit is set on its selected edge even when the pin's mask bit (setup bit p = 1) is set.
- R7: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R8: When an edge and a write-one-to-clear hit the same flag bit in the same cycle, the bit ends up set.
- R9: `irq` equals, one cycle later, the OR over all pins of (flag AND NOT mask).
- R10: Mode 10 behaves as an input: no pad drive, the input is readable, and no flag is set. Mode 00 sets no flags either.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 6 | Byte address {kind, port, 0} |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_in | input | 40 | Asynchronous pad inputs |
| pad_oe | output | 40 | Per-pin output enable |
| pad_out | output | 40 | Per-pin output value |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The bench builds the block with its defaults: five ports and two synchronizer stages. With five ports the 3-bit port field has three codes (5, 6 and 7) with no register behind them, so out-of-range decoding is reachable from the bus. With two stages the fixed three-edge latency from input to flag can be hit exactly. That latency is what lets the bench place a clearing write on the very edge where a flag sets. A random phase then mixes writes to every address with pin toggles on all 40 pins, checked against the cycle model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PINS_PER_PORT = 8;
    localparam int REG_W         = 16;
    localparam int MODE_W        = 2;

    typedef enum logic [1:0] {
        MODE_IN   = 2'b00,
        MODE_OUT  = 2'b01,
        MODE_RSV  = 2'b10,
        MODE_EDGE = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        KIND_CFG  = 2'd0,
        KIND_DATA = 2'd1,
        KIND_ICTL = 2'd2,
        KIND_FLAG = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic [REG_W-1:0]         cfg;
        logic [PINS_PER_PORT-1:0] dout;
        logic [PINS_PER_PORT-1:0] mask;
        logic [PINS_PER_PORT-1:0] trig;
        logic [PINS_PER_PORT-1:0] flag;
        logic [PINS_PER_PORT-1:0] prev;
    } port_state_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PINS_PER_PORT-1:0] pin_sync,
    input  logic                     wr_cfg,
    input  logic                     wr_data,
    input  logic                     wr_ictl,
    input  logic                     wr_flag,
    input  logic [REG_W-1:0]         wdata,
    output logic [REG_W-1:0]         cfg_o,
    output logic [PINS_PER_PORT-1:0] dout_o,
    output logic [PINS_PER_PORT-1:0] mask_o,
    output logic [PINS_PER_PORT-1:0] trig_o,
    output logic [PINS_PER_PORT-1:0] flag_o,
    output logic [PINS_PER_PORT-1:0] oe_o,
    output logic [PINS_PER_PORT-1:0] rd_data_o
);
    port_state_t st_d, st_q;
    logic [PINS_PER_PORT-1:0] hit;
    logic [PINS_PER_PORT-1:0] clr;

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < PINS_PER_PORT; p++) begin
            pin_mode_e mode;
            mode   = pin_mode_e'(st_q.cfg[MODE_W*p +: MODE_W]);
            hit[p] = (mode == MODE_EDGE) &&
                     (st_q.trig[p] ? (pin_sync[p] && !st_q.prev[p])
                                   : (!pin_sync[p] && st_q.prev[p]));
            oe_o[p]      = (mode == MODE_OUT);
            rd_data_o[p] = oe_o[p] ? st_q.dout[p] : pin_sync[p];
        end
        clr        = wr_flag ? wdata[PINS_PER_PORT-1:0] : '0;
        st_d.flag  = (st_q.flag & ~clr) | hit;
        st_d.prev  = pin_sync;
        if (wr_cfg)  st_d.cfg  = wdata;
        if (wr_data) st_d.dout = wdata[PINS_PER_PORT-1:0];
        if (wr_ictl) begin
            st_d.mask = wdata[PINS_PER_PORT-1:0];
            st_d.trig = wdata[2*PINS_PER_PORT-1:PINS_PER_PORT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o  = st_q.cfg;
    assign dout_o = st_q.dout;
    assign mask_o = st_q.mask;
    assign trig_o = st_q.trig;
    assign flag_o = st_q.flag;
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PORTS   = 5,
    parameter int SYNC_STAGES = 2,
    localparam int NPINS      = NUM_PORTS * PINS_PER_PORT,
    localparam int PORT_AW    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W     = PORT_AW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic              irq
);
    reg_kind_e           kind;
    logic [PORT_AW-1:0]  port_idx;
    logic                aligned;
    logic                wr_any;
    logic [NPINS-1:0]    pin_sync;

    logic [REG_W-1:0]         cfg_a   [NUM_PORTS];
    logic [PINS_PER_PORT-1:0] dout_a  [NUM_PORTS];
    logic [PINS_PER_PORT-1:0] mask_a  [NUM_PORTS];
    logic [PINS_PER_PORT-1:0] trig_a  [NUM_PORTS];
    logic [PINS_PER_PORT-1:0] flag_a  [NUM_PORTS];
    logic [PINS_PER_PORT-1:0] rdd_a   [NUM_PORTS];

    logic [NPINS-1:0]         flag_flat;
    logic [NPINS-1:0]         mask_flat;
    logic [2*NPINS-1:0]       cfg_flat;

    logic irq_d, irq_q;

    assign kind     = reg_kind_e'(bus_addr[ADDR_W-1 -: 2]);
    assign port_idx = bus_addr[PORT_AW:1];
    assign aligned  = ~bus_addr[0];
    assign wr_any   = bus_sel & bus_wr & aligned;

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        logic hit_port;
        assign hit_port = wr_any && (port_idx == PORT_AW'(g));

        gpio_port u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_sync  (pin_sync[g*PINS_PER_PORT +: PINS_PER_PORT]),
            .wr_cfg    (hit_port && (kind == KIND_CFG)),
            .wr_data   (hit_port && (kind == KIND_DATA)),
            .wr_ictl   (hit_port && (kind == KIND_ICTL)),
            .wr_flag   (hit_port && (kind == KIND_FLAG)),
            .wdata     (bus_wdata),
            .cfg_o     (cfg_a[g]),
            .dout_o    (dout_a[g]),
            .mask_o    (mask_a[g]),
            .trig_o    (trig_a[g]),
            .flag_o    (flag_a[g]),
            .oe_o      (pad_oe[g*PINS_PER_PORT +: PINS_PER_PORT]),
            .rd_data_o (rdd_a[g])
        );

        assign pad_out  [g*PINS_PER_PORT +: PINS_PER_PORT] = dout_a[g];
        assign flag_flat[g*PINS_PER_PORT +: PINS_PER_PORT] = flag_a[g];
        assign mask_flat[g*PINS_PER_PORT +: PINS_PER_PORT] = mask_a[g];
        assign cfg_flat [g*REG_W +: REG_W]                 = cfg_a[g];
    end

    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < NUM_PORTS; g++) begin
            if (aligned && (port_idx == PORT_AW'(g))) begin
                case (kind)
                    KIND_CFG:  bus_rdata = cfg_a[g];
                    KIND_DATA: bus_rdata = {{(REG_W-PINS_PER_PORT){1'b0}}, rdd_a[g]};
                    KIND_ICTL: bus_rdata = {trig_a[g], mask_a[g]};
                    KIND_FLAG: bus_rdata = {{(REG_W-PINS_PER_PORT){1'b0}}, flag_a[g]};
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end

    always_comb begin
        irq_d = |(flag_flat & ~mask_flat);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;
endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
    parameter int NUM_PORTS = 5,
    parameter int ADDR_W    = 6,
    localparam int NPINS    = NUM_PORTS * 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  pad_out,
    input logic              irq,
    input logic [NPINS-1:0]  flag_flat,
    input logic [NPINS-1:0]  mask_flat,
    input logic [2*NPINS-1:0] cfg_flat
);
    logic [NPINS-1:0] det_en;
    logic             wr_flag_reg;
    logic             wr_data_reg;

    for (genvar i = 0; i < NPINS; i++) begin : g_det
        assign det_en[i] = (cfg_flat[2*i +: 2] == 2'b11);
    end

    assign wr_flag_reg = bus_sel && bus_wr && !bus_addr[0] && (bus_addr[ADDR_W-1 -: 2] == 2'd3);
    assign wr_data_reg = bus_sel && bus_wr && !bus_addr[0] && (bus_addr[ADDR_W-1 -: 2] == 2'd1);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((&mask_flat) && (flag_flat == '0) && !irq)); // R1

    AST_PAD_OUT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out != $past(pad_out)) |-> $past(wr_data_reg)); // R2

    AST_FLAG_NEEDS_EDGE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_flat & ~$past(flag_flat) & ~$past(det_en)) == '0)); // R5

    AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flag_flat) & ~flag_flat) != '0) |-> $past(wr_flag_reg)); // R7

    AST_IRQ_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(flag_flat & ~mask_flat))); // R9
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .pad_out   (pad_out),
    .irq       (irq),
    .flag_flat (flag_flat),
    .mask_flat (mask_flat),
    .cfg_flat  (cfg_flat)
);

// File: tb/gpio_edge_ctrl_bench.sv
`timescale 1ns/100ps
module gpio_edge_ctrl_bench;
    localparam int NP = 5;
    localparam int N  = NP * 8;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_sel = 0;
    logic        bus_wr = 0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pad_oe;
    logic [N-1:0] pad_out;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    gpio_edge_ctrl u_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_s1[N], m_s2[N], m_prev[N], m_mode[N], m_dout[N], m_mask[N], m_trig[N], m_flag[N];
    int m_irq;

    function automatic logic [15:0] exp_rd(input logic [5:0] a);
        logic [15:0] r;
        int kd, pt;
        r  = '0;
        kd = int'(a[5:4]);
        pt = int'(a[3:1]);
        if (a[0] == 1'b0 && pt < NP) begin
            for (int p = 0; p < 8; p++) begin
                int i;
                i = pt * 8 + p;
                case (kd)
                    0: r[2*p +: 2] = 2'(m_mode[i]);
                    1: r[p] = (m_mode[i] == 1) ? 1'(m_dout[i]) : 1'(m_s2[i]);
                    2: begin r[p] = 1'(m_mask[i]); r[8+p] = 1'(m_trig[i]); end
                    default: r[p] = 1'(m_flag[i]);
                endcase
            end
        end
        return r;
    endfunction

    always @(posedge clk) begin
        logic [N-1:0] e_oe, e_out;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0; m_mode[i] = 0;
                m_dout[i] = 0; m_mask[i] = 1; m_trig[i] = 0; m_flag[i] = 0;
            end
            m_irq = 0;
        end else begin
            int kd, pt;
            bit wr;
            kd = int'(bus_addr[5:4]);
            pt = int'(bus_addr[3:1]);
            wr = bus_sel && bus_wr && !bus_addr[0] && pt < NP;
            m_irq = 0;
            for (int i = 0; i < N; i++) if (m_flag[i] == 1 && m_mask[i] == 0) m_irq = 1;
            for (int i = 0; i < N; i++) begin
                int edge_hit, clr, p;
                p = i % 8;
                edge_hit = 0;
                if (m_mode[i] == 3) begin
                    if (m_trig[i] == 1) edge_hit = (m_s2[i] == 1 && m_prev[i] == 0) ? 1 : 0;
                    else                edge_hit = (m_s2[i] == 0 && m_prev[i] == 1) ? 1 : 0;
                end
                clr = (wr && kd == 3 && i / 8 == pt && bus_wdata[p]) ? 1 : 0;
                m_flag[i] = ((m_flag[i] == 1 && clr == 0) || edge_hit == 1) ? 1 : 0;
                m_prev[i] = m_s2[i];
                m_s2[i]   = m_s1[i];
                m_s1[i]   = int'(pin_in[i]);
                if (wr && i / 8 == pt) begin
                    case (kd)
                        0: m_mode[i] = int'(bus_wdata[2*p +: 2]);
                        1: m_dout[i] = int'(bus_wdata[p]);
                        2: begin m_mask[i] = int'(bus_wdata[p]); m_trig[i] = int'(bus_wdata[8+p]); end
                        default: ;
                    endcase
                end
            end
        end
        #1;
        for (int i = 0; i < N; i++) begin
            e_oe[i]  = (m_mode[i] == 1);
            e_out[i] = 1'(m_dout[i]);
        end
        chk("R9 model irq", 64'(irq), 64'(m_irq));
        chk("R2 model pad_oe", 64'(pad_oe), 64'(e_oe));
        chk("R2 model pad_out", 64'(pad_out), 64'(e_out));
        chk("R4 model rdata", 64'(bus_rdata), 64'(exp_rd(bus_addr)));
    end

    function automatic logic [5:0] ra(input int kd, input int pt);
        return {2'(kd), 3'(pt), 1'b0};
    endfunction

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [15:0] exp);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk);
        #1;
        chk(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic out_chk(input string tag, input logic [63:0] act_sel, input logic [63:0] exp);
        chk(tag, act_sel, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd_chk("R1 cfg p0", ra(0,0), 16'h0000);
        rd_chk("R1 ictl p3", ra(2,3), 16'h00FF);
        rd_chk("R1 flag p4", ra(3,4), 16'h0000);
        #0 chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 pad_oe", 64'(pad_oe), 64'd0);

        // R2 output mode on port 1
        wr(ra(0,1), 16'h5555);
        wr(ra(1,1), 16'h00A5);
        @(posedge clk); #1;
        chk("R2 oe port1", 64'(pad_oe[15:8]), 64'hFF);
        chk("R2 out port1", 64'(pad_out[15:8]), 64'hA5);
        chk("R4 oe port0 untouched", 64'(pad_oe[7:0]), 64'h00);
        rd_chk("R3 data port1 driven", ra(1,1), 16'h00A5);
        rd_chk("R4 cfg p0 untouched", ra(0,0), 16'h0000);
        rd_chk("R4 cfg p1", ra(0,1), 16'h5555);

        // R3 input read latency
        @(negedge clk); pin_in[7:0] = 8'h3C;
        rd_chk("R3 data port0 input", ra(1,0), 16'h003C);

        // R5 / R7 edges on port 2
        wr(ra(0,2), 16'hFFFF);
        wr(ra(2,2), 16'hF000);
        @(negedge clk); pin_in[23:16] = 8'hFF;
        repeat (4) @(negedge clk);
        rd_chk("R5 rising flags p2", ra(3,2), 16'h00F0);
        chk("R9 irq set", 64'(irq), 64'd1);
        wr(ra(3,2), 16'h0030);
        rd_chk("R7 w1c p2", ra(3,2), 16'h00C0);
        wr(ra(3,2), 16'h0000);
        rd_chk("R7 write zero p2", ra(3,2), 16'h00C0);
        @(negedge clk); pin_in[23:16] = 8'h00;
        repeat (4) @(negedge clk);
        rd_chk("R5 falling flags p2", ra(3,2), 16'h00CF);
        wr(ra(3,2), 16'hFFFF);
        repeat (2) @(negedge clk);
        @(posedge clk); #1;
        chk("R9 irq cleared", 64'(irq), 64'd0);

        // R6 masked pins still flag
        wr(ra(0,3), 16'hFFFF);
        wr(ra(2,3), 16'hFFFF);
        @(negedge clk); pin_in[31:24] = 8'h81;
        repeat (4) @(negedge clk);
        rd_chk("R6 masked flags p3", ra(3,3), 16'h0081);
        chk("R6 masked irq low", 64'(irq), 64'd0);
        wr(ra(2,3), 16'hFF7E);
        repeat (2) @(negedge clk);
        @(posedge clk); #1;
        chk("R9 unmask raises irq", 64'(irq), 64'd1);
        wr(ra(3,3), 16'hFFFF);
        repeat (2) @(negedge clk);
        @(posedge clk); #1;
        chk("R9 irq low after clear", 64'(irq), 64'd0);

        // R8 set wins over clear
        wr(ra(0,4), 16'h0003);
        wr(ra(2,4), 16'h01FE);
        @(negedge clk); pin_in[32] = 1'b1;
        repeat (4) @(negedge clk);
        rd_chk("R5 p4 pin0 flag", ra(3,4), 16'h0001);
        @(negedge clk); pin_in[32] = 1'b0;
        repeat (4) @(negedge clk);
        rd_chk("R5 falling ignored p4", ra(3,4), 16'h0001);
        @(negedge clk); pin_in[32] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = ra(3,4); bus_wdata = 16'h0001;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        rd_chk("R8 set wins", ra(3,4), 16'h0001);
        wr(ra(3,4), 16'h0001);
        rd_chk("R7 clear p4", ra(3,4), 16'h0000);

        // R10 reserved mode
        wr(ra(0,0), 16'h0002);
        wr(ra(2,0), 16'h0100);
        @(negedge clk); pin_in[0] = 1'b1;
        repeat (4) @(negedge clk);
        rd_chk("R10 no flag reserved", ra(3,0), 16'h0000);
        rd_chk("R10 input readable", ra(1,0), 16'h003D);
        chk("R10 no drive", 64'(pad_oe[0]), 64'd0);

        // R4 out-of-range and odd addresses
        wr(ra(1,5), 16'hFFFF);
        rd_chk("R4 port5 reads 0", ra(1,5), 16'h0000);
        wr(6'h13, 16'h0000);
        rd_chk("R4 odd addr reads 0", 6'h13, 16'h0000);
        rd_chk("R4 port1 data kept", ra(1,1), 16'h00A5);

        // Random phase against the model
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) begin
                bus_sel = 1; bus_wr = 1;
                bus_addr = 6'($urandom_range(0, 63));
                bus_wdata = 16'($urandom);
            end else begin
                bus_sel = 0; bus_wr = 0;
                bus_addr = 6'($urandom_range(0, 63));
            end
            if ($urandom_range(0, 2) == 0) pin_in[$urandom_range(0, N-1)] ^= 1'b1;
        end
        @(negedge clk); bus_sel = 0; bus_wr = 0;
        repeat (4) @(negedge clk);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule